// File: doc/BRIEF.md
# Electronic Shutter Sweep Sequencer

This block sets the exposure time of a frame-transfer image sensor by controlling when the substrate-sweep pulses stop. It tracks each line by counting master-clock rises from the falling edge of the horizontal sync. It numbers the lines within each vertical period, and it counts vertical periods inside an exposure group. An exposure group is made of `shut_vcnt_i + 1` vertical periods. The last vertical-sync fall of a group ends the exposure and, in the same cycle, starts the next group. All three shutter settings are sampled only at that group-start fall, so no group ever mixes old and new values.

Inside a group, the sweep pulses run through whole vertical periods up to a chosen period. In that period they stop after a programmed number of lines. The exposure time is therefore the remaining lines of that period plus every later period of the group. Moving the chosen period one step at a time, from 0 up to the group length, changes the exposure smoothly between long and short shutter times. On the first line of a group that carries no sweep, an exposure flag goes high. It rises at a mid-line position when a sweep occurred earlier in the group, and at a later position when the group had no sweep at all. The flag stays high until the group ends.

Top module: `shutter_sequencer`

## Requirements
- R1: After reset, and until the first vertical-sync fall, `sweep_o` and `expose_o` are 0 regardless of the sync inputs and the settings.
- R2: Position 1 is the first clock rise at which a low horizontal sync is sampled after a high one, and the position then increments by one on each later rise. On a line that carries a sweep, `sweep_o` is high exactly for positions `SWEEP_POS` through `SWEEP_POS+SWEEP_LEN-1`.
- R3: `shut_vcnt_i`, `shut_hvcnt_i` and `shut_lcnt_i` are sampled only at the vertical-sync fall that starts a group. Changing them inside a group has no effect on that group's sweeps or flag.
- R4: A group spans `shut_vcnt_i+1` vertical periods, indexed from 0. Let the sweep period be `shut_hvcnt_i` clamped to at most `shut_vcnt_i`. Every line of a period with an index below the sweep period carries a sweep.
- R5: In the sweep period itself, the lines with an index below `shut_lcnt_i` carry a sweep. Line 0 is the line that begins at the vertical-sync fall.
- R6: Periods after the sweep period carry no sweep. A `shut_hvcnt_i` value above `shut_vcnt_i` acts as `shut_vcnt_i`.
- R7: If an earlier line of the group carried a sweep, `expose_o` rises at position `EXP_MID` of the first line of the group that carries no sweep.
- R8: If no earlier line of the group carried a sweep, `expose_o` rises at position `EXP_NONE` of the first line of the group that carries no sweep.
- R9: Once high, `expose_o` stays high and `sweep_o` stays low. Both hold until the group-start vertical-sync fall, at which `expose_o` returns to 0 from position 1.
- R10: A group yields exactly `hv*L + min(lcnt, L)` sweep pulses, where `hv` is the clamped sweep period, `lcnt` is the sampled line count, and `L` is the number of lines in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync; its falling edge starts a line |
| vsync_i | input | 1 | Vertical sync; its falling edge, aligned with a horizontal fall, starts a period |
| shut_vcnt_i | input | VCNT_W | Number of vertical periods in a group, minus one |
| shut_hvcnt_i | input | VCNT_W | Index of the period in which the sweeps stop |
| shut_lcnt_i | input | LCNT_W | Lines swept in the stopping period |
| sweep_o | output | 1 | Substrate-sweep pulse stream |
| expose_o | output | 1 | Exposure flag, high from the start of exposure to the end of the group |

## Verification
The assertions check four behaviours on every cycle. Sweeps never coexist with a raised exposure flag. The flag rises only at one of the two allowed positions and falls only at a group start. The sampled settings hold steady between group starts, and the period index never runs past the group length. Only the bench's scenarios can show the pulse counts per group, where exactly the sweeps stop, the clamping of the sweep period, which of the two positions the flag chooses, and the fact that settings changed inside a group are ignored. To do this, the bench compares the outputs against a line-by-line model, both for directed corner settings and for random ones.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sync_fall_det.sv
module sync_fall_det #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b1;
      else         prev_q[g] <= sync_i[g];
    end
    assign fall_o[g] = prev_q[g] & ~sync_i[g];
  end
endmodule

// File: rtl/line_timer.sv
module line_timer #(
  parameter int POS_W  = 12,
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_fall_i,
  input  logic              vs_fall_i,
  output logic [POS_W-1:0]  pos_o,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [POS_W-1:0]  POS_MAX  = '1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o  <= '0;
      line_o <= '0;
    end else begin
      if (hs_fall_i)             pos_o <= POS_W'(1);
      else if (pos_o != POS_MAX) pos_o <= pos_o + 1'b1;
      if (hs_fall_i) begin
        if (vs_fall_i)               line_o <= '0;
        else if (line_o != LINE_MAX) line_o <= line_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
  import shutter_pkg::*;
#(
  parameter int VCNT_W    = 10,
  parameter int LCNT_W    = 12,
  parameter int POS_W     = 12,
  parameter int SWEEP_POS = 40,
  parameter int SWEEP_LEN = 24,
  parameter int EXP_MID   = 1515,
  parameter int EXP_NONE  = 1590
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vs_fall_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [LCNT_W-1:0] line_i,
  input  logic [VCNT_W-1:0] vcnt_i,
  input  logic [VCNT_W-1:0] hvcnt_i,
  input  logic [LCNT_W-1:0] lcnt_i,
  output logic              sweep_o,
  output logic              expose_o
);
  localparam logic [POS_W-1:0] WIN_LO   = POS_W'(SWEEP_POS);
  localparam logic [POS_W-1:0] WIN_HI   = POS_W'(SWEEP_POS + SWEEP_LEN);
  localparam logic [POS_W-1:0] MID_PRE  = POS_W'(EXP_MID - 1);
  localparam logic [POS_W-1:0] NONE_PRE = POS_W'(EXP_NONE - 1);
  localparam logic [POS_W-1:0] MID_AT   = POS_W'(EXP_MID);
  localparam logic [POS_W-1:0] NONE_AT  = POS_W'(EXP_NONE);

  seq_state_e        state_q;
  logic [VCNT_W-1:0] vcnt_q, hv_q, vidx_q, hv_eff;
  logic [LCNT_W-1:0] lcnt_q;
  logic              swept_q, expose_q;
  logic              grp_start, sweep_line, in_win;
  logic [POS_W-1:0]  exp_pre;

  assign grp_start  = vs_fall_i && (state_q == ST_IDLE || vidx_q == vcnt_q);
  assign hv_eff     = (hv_q > vcnt_q) ? vcnt_q : hv_q;
  assign sweep_line = (state_q == ST_RUN) &&
                      ((vidx_q < hv_eff) || (vidx_q == hv_eff && line_i < lcnt_q));
  assign in_win     = (pos_i >= WIN_LO) && (pos_i < WIN_HI);
  assign sweep_o    = sweep_line && in_win;
  assign exp_pre    = swept_q ? MID_PRE : NONE_PRE;
  assign expose_o   = expose_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      vcnt_q   <= '0;
      hv_q     <= '0;
      lcnt_q   <= '0;
      vidx_q   <= '0;
      swept_q  <= 1'b0;
      expose_q <= 1'b0;
    end else if (grp_start) begin
      state_q  <= ST_RUN;
      vcnt_q   <= vcnt_i;
      hv_q     <= hvcnt_i;
      lcnt_q   <= lcnt_i;
      vidx_q   <= '0;
      swept_q  <= 1'b0;
      expose_q <= 1'b0;
    end else begin
      if (vs_fall_i)  vidx_q  <= vidx_q + 1'b1;
      if (sweep_line) swept_q <= 1'b1;
      if (state_q == ST_RUN && !sweep_line && !expose_q && pos_i == exp_pre)
        expose_q <= 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!sweep_o && !expose_q));

  p_hold_settings_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_start |=> ($stable(vcnt_q) && $stable(hv_q) && $stable(lcnt_q)));

  p_period_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vidx_q <= vcnt_q);

  // R7 and R8: the flag rises only at one of its two positions
  p_expose_pos_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expose_q) |-> (pos_i == MID_AT || pos_i == NONE_AT));

  p_no_sweep_exposed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expose_q |-> !sweep_o);

  p_expose_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(expose_q) |-> $past(grp_start));
endmodule

// File: rtl/shutter_sequencer.sv
module shutter_sequencer #(
  parameter int VCNT_W    = 10,
  parameter int LCNT_W    = 12,
  parameter int POS_W     = 12,
  parameter int SWEEP_POS = 40,
  parameter int SWEEP_LEN = 24,
  parameter int EXP_MID   = 1515,
  parameter int EXP_NONE  = 1590
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic [VCNT_W-1:0] shut_vcnt_i,
  input  logic [VCNT_W-1:0] shut_hvcnt_i,
  input  logic [LCNT_W-1:0] shut_lcnt_i,
  output logic              sweep_o,
  output logic              expose_o
);
  logic [1:0]        falls;
  logic [POS_W-1:0]  pos;
  logic [LCNT_W-1:0] line;

  sync_fall_det #(.N(2)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i ({vsync_i, hsync_i}),
    .fall_o (falls)
  );

  line_timer #(.POS_W(POS_W), .LINE_W(LCNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hs_fall_i (falls[0]),
    .vs_fall_i (falls[1]),
    .pos_o     (pos),
    .line_o    (line)
  );

  shutter_seq #(
    .VCNT_W(VCNT_W), .LCNT_W(LCNT_W), .POS_W(POS_W),
    .SWEEP_POS(SWEEP_POS), .SWEEP_LEN(SWEEP_LEN),
    .EXP_MID(EXP_MID), .EXP_NONE(EXP_NONE)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vs_fall_i (falls[1]),
    .pos_i     (pos),
    .line_i    (line),
    .vcnt_i    (shut_vcnt_i),
    .hvcnt_i   (shut_hvcnt_i),
    .lcnt_i    (shut_lcnt_i),
    .sweep_o   (sweep_o),
    .expose_o  (expose_o)
  );
endmodule

// File: tb/shutter_sequencer_bench.sv
module shutter_sequencer_bench;
  localparam int VW = 4, LW = 4, PW = 8;
  localparam int SP = 4, SL = 3, EM = 12, EN = 16;
  localparam int LEN = 20, NL = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, hs, vs;
  logic [VW-1:0] svd_in, hv_in;
  logic [LW-1:0] lc_in;
  logic sweep, expose;

  shutter_sequencer #(
    .VCNT_W(VW), .LCNT_W(LW), .POS_W(PW), .SWEEP_POS(SP), .SWEEP_LEN(SL),
    .EXP_MID(EM), .EXP_NONE(EN)
  ) u_shutter_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs),
    .shut_vcnt_i(svd_in), .shut_hvcnt_i(hv_in), .shut_lcnt_i(lc_in),
    .sweep_o(sweep), .expose_o(expose)
  );

  int checks = 0, fails = 0;
  bit m_armed = 0, m_swept = 0, m_exp = 0, mid_flag = 0, prev_sw = 0;
  int m_svd = 0, m_hv = 0, m_lc = 0, m_vidx = 0, m_line = 0, pulse_cnt = 0;

  function automatic int hv_eff_f(int s, int h);
    return (h > s) ? s : h;
  endfunction

  function automatic int exp_pulses(int s, int h, int l);
    return hv_eff_f(s, h) * NL + ((l < NL) ? l : NL);
  endfunction

  task automatic chk(logic act, logic exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_count();
    if (m_armed) begin
      checks++;
      if (pulse_cnt != exp_pulses(m_svd, m_hv, m_lc)) begin
        fails++;
        $display("FAIL %s pulse count actual=%0d expected=%0d", mid_flag ? "R3" : "R10",
                 pulse_cnt, exp_pulses(m_svd, m_hv, m_lc));
      end
    end
    pulse_cnt = 0;
  endtask

  task automatic do_line(bit vf);
    int he;
    bit sl, esw;
    string ts, te;
    @(negedge clk);
    hs = 1'b0;
    if (vf) vs = 1'b0;
    if (vf) begin
      if (!m_armed || m_vidx == m_svd) begin
        check_count();
        m_armed = 1; m_svd = svd_in; m_hv = hv_in; m_lc = lc_in;
        m_vidx = 0; m_swept = 0; m_exp = 0; mid_flag = 0;
      end else m_vidx++;
      m_line = 0;
    end else if (m_line < 15) m_line++;
    he = hv_eff_f(m_svd, m_hv);
    sl = m_armed && (m_vidx < he || (m_vidx == he && m_line < m_lc));
    for (int c = 1; c <= LEN; c++) begin
      @(posedge clk);
      #5;
      esw = sl && c >= SP && c < SP + SL;
      if (!m_exp && m_armed && !sl && c == (m_swept ? EM : EN)) m_exp = 1;
      if (!m_armed) ts = "R1";
      else if (sl && c >= SP - 1 && c <= SP + SL) ts = "R2";
      else if (m_vidx < he) ts = "R4";
      else if (m_vidx == he) ts = "R5";
      else ts = "R6";
      if (!m_armed) te = "R1";
      else if (m_exp || (vf && m_vidx == 0 && c == 1)) te = "R9";
      else te = m_swept ? "R7" : "R8";
      chk(sweep, esw, ts, "sweep");
      chk(expose, m_exp, te, "expose");
      if (sweep && !prev_sw) pulse_cnt++;
      prev_sw = sweep;
      if (c == 2) begin hs = 1'b1; vs = 1'b1; end
    end
    if (sl) m_swept = 1;
  endtask

  task automatic run_group(int s, int h, int l, bit mid);
    svd_in = VW'(s); hv_in = VW'(h); lc_in = LW'(l);
    for (int p = 0; p <= s; p++) begin
      for (int ln = 0; ln < NL; ln++) begin
        do_line(ln == 0);
        if (mid && p == 0 && ln == 0) begin
          svd_in = VW'(s + 1); hv_in = VW'(h + 3); lc_in = LW'(l + 2);
          mid_flag = 1;
        end
      end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; hs = 1'b1; vs = 1'b1;
    svd_in = '0; hv_in = '0; lc_in = '0;
    repeat (3) @(posedge clk);
    #5;
    chk(sweep, 1'b0, "R1", "reset sweep");
    chk(expose, 1'b0, "R1", "reset expose");
    @(negedge clk);
    rst_n = 1'b1;
    svd_in = 4'd2; hv_in = 4'd3; lc_in = 4'd3;
    do_line(0);
    do_line(0);
    run_group(2, 1, 3, 0);
    run_group(0, 0, 0, 0);
    run_group(1, 5, 2, 0);
    run_group(1, 0, 5, 0);
    run_group(0, 0, 7, 0);
    run_group(3, 2, 1, 1);
    run_group(2, 2, 0, 0);
    for (int i = 0; i < 14; i++)
      run_group($urandom_range(3, 0), $urandom_range(4, 0), $urandom_range(7, 0),
                (i % 5) == 2);
    svd_in = '0; hv_in = '0; lc_in = '0;
    do_line(1);
    finish_run();
  end
endmodule